// File: doc/BRIEF.md
# DMA Channel Transfer Count Unit

This block keeps the transfer count of a single DMA channel, widened to 24 bits. It holds two copies of the count. The base copy keeps the value that software programmed. The current copy counts down as transfers complete. Software loads the lower 16 bits one byte at a time through an 8-bit count port. A byte-pointer flip-flop decides which byte each access reaches. A separate 8-bit port loads the top byte. Any write to the lower port clears the top byte, so the top byte must always be written last.

Every transfer pulse decrements the current count. When the count wraps from zero to all ones, the block raises a one-cycle terminal-count strobe. If autoinitialize is on, the current count is restored from the base copy at that moment. If it is off, the current count stays at all ones.

In chaining mode, writes reach only the base copy, so software can queue the next buffer while the present one is still counting down. The base copy cannot be read. Reads and the count output always show the current copy. The meaning of the count (words or bytes) belongs to the transfer engine and does not change this logic.

Top module: `dma_xfer_count`

## Requirements
- R1: After reset, and in the cycle after a master clear, the current count is 0, the terminal-count strobe is low and the byte pointer selects the low byte. Master clear takes priority over every other input.
- R2: Each write to the low count port stores the data byte in the lane chosen by the byte pointer and then advances the pointer: lane 0 (bits 7:0) first, then lane 1 (bits 15:8), then back to lane 0. A pointer-clear strobe returns the pointer to lane 0.
- R3: Any write to the low count port sets bits 23:16 of the count to 00h. A write to the high port loads bits 23:16 with the data byte.
- R4: In normal mode (chain mode low), a count write updates the base and the current copies with the same byte.
- R5: In chaining mode (chain mode high), count writes change only the base copy. The current count and its output do not change.
- R6: A transfer pulse with no count write in the same cycle lowers a nonzero current count by exactly 1 in the next cycle.
- R7: A transfer pulse at a current count of 0 raises the terminal-count strobe for exactly one cycle. Without autoinitialize, the count then reads FFFFFFh.
- R8: With autoinitialize on, a terminal count reloads the current count from the base copy. A decrement that does not wrap never reloads.
- R9: When a count write and a transfer pulse arrive in the same cycle, the write takes effect, no decrement happens and no terminal count is raised.
- R10: The read data bus shows current-count bits 23:16 while the high read is asserted. Otherwise it shows the lane chosen by the byte pointer. A low read advances the pointer just as a low write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr_i | input | 1 | Master clear, synchronous |
| ptr_clr_i | input | 1 | Returns byte pointer to lane 0 |
| lo_wr_i | input | 1 | Write strobe, low count port |
| lo_rd_i | input | 1 | Read strobe, low count port |
| hi_wr_i | input | 1 | Write strobe, high count port |
| hi_rd_i | input | 1 | Read select, high count port |
| wdata_i | input | 8 | Write data |
| chain_mode_i | input | 1 | 1: writes reach the base copy only |
| auto_init_i | input | 1 | 1: reload on terminal count |
| xfer_i | input | 1 | One completed transfer |
| rdata_o | output | 8 | Read data from the current count |
| tc_o | output | 1 | Terminal-count strobe |
| count_o | output | 24 | Current count |

## Verification
The base copy is hidden, so a wrong base value does not show up until a terminal count occurs with autoinitialize on. At that moment, in the cycle after the wrapping pulse, the count output holds the wrong reload value. For this reason the chaining and autoinitialize scenarios count all the way down to a reload. A byte pointer left in the wrong lane shows up on the next single-byte write as data in the wrong lane of the count output. A wrong high byte after a low write shows up on the count output in the very next cycle. A missing or stretched strobe, or a decrement in a write cycle, shows up on the count output or the strobe one cycle after the pulse.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;

   // Selects which copy of the count a write reaches.
   typedef enum logic {
      WR_BOTH = 1'b0,
      WR_BASE = 1'b1
   } wr_target_e;

   function automatic int unsigned ptr_width(input int unsigned lanes);
      return (lanes > 1) ? $clog2(lanes) : 1;
   endfunction

endpackage

// File: rtl/dmac_byte_ptr.sv
module dmac_byte_ptr #(
   parameter int unsigned LANES = 2,
   parameter int unsigned PTR_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   output logic [PTR_W-1:0] ptr_o
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(LANES - 1);

   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (clr_i) begin
         ptr_q <= '0;
      end else if (adv_i) begin
         ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   end

   assign ptr_o = ptr_q;

endmodule

// File: rtl/dmac_count_next.sv
module dmac_count_next #(
   parameter int unsigned CNT_W = 24
) (
   input  logic [CNT_W-1:0] cur_i,
   input  logic [CNT_W-1:0] base_i,
   input  logic             auto_init_i,
   output logic [CNT_W-1:0] nxt_o,
   output logic             wrap_o
);

   always_comb begin
      wrap_o = (cur_i == '0);
      if (wrap_o && auto_init_i) begin
         nxt_o = base_i;
      end else begin
         nxt_o = cur_i - 1'b1;
      end
   end

endmodule

// File: rtl/dmac_count_regs.sv
module dmac_count_regs
   import dma_cnt_pkg::*;
#(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned LOW_W  = 16,
   parameter int unsigned HIGH_W = 8,
   parameter int unsigned LANES  = LOW_W / BUS_W,
   parameter int unsigned PTR_W  = 1,
   parameter int unsigned CNT_W  = LOW_W + HIGH_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mclr_i,
   input  logic             lo_wr_i,
   input  logic             hi_wr_i,
   input  logic [PTR_W-1:0] ptr_i,
   input  logic [BUS_W-1:0] wdata_i,
   input  wr_target_e       target_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] step_val_i,
   output logic [CNT_W-1:0] base_o,
   output logic [CNT_W-1:0] cur_o
);

   logic [LOW_W-1:0]  base_lo_q, cur_lo_q;
   logic [HIGH_W-1:0] base_hi_q, cur_hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_lo_q <= '0;
         base_hi_q <= '0;
         cur_lo_q  <= '0;
         cur_hi_q  <= '0;
      end else if (mclr_i) begin
         base_lo_q <= '0;
         base_hi_q <= '0;
         cur_lo_q  <= '0;
         cur_hi_q  <= '0;
      end else if (lo_wr_i) begin
         for (int unsigned l = 0; l < LANES; l++) begin
            if (ptr_i == PTR_W'(l)) begin
               base_lo_q[l*BUS_W +: BUS_W] <= wdata_i;
               if (target_i == WR_BOTH) begin
                  cur_lo_q[l*BUS_W +: BUS_W] <= wdata_i;
               end
            end
         end
         base_hi_q <= '0;
         if (target_i == WR_BOTH) begin
            cur_hi_q <= '0;
         end
      end else if (hi_wr_i) begin
         base_hi_q <= wdata_i[HIGH_W-1:0];
         if (target_i == WR_BOTH) begin
            cur_hi_q <= wdata_i[HIGH_W-1:0];
         end
      end else if (step_i) begin
         {cur_hi_q, cur_lo_q} <= step_val_i;
      end
   end

   assign base_o = {base_hi_q, base_lo_q};
   assign cur_o  = {cur_hi_q, cur_lo_q};

endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count
   import dma_cnt_pkg::*;
#(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned LOW_W  = 16,
   parameter int unsigned HIGH_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      mclr_i,
   input  logic                      ptr_clr_i,
   input  logic                      lo_wr_i,
   input  logic                      lo_rd_i,
   input  logic                      hi_wr_i,
   input  logic                      hi_rd_i,
   input  logic [BUS_W-1:0]          wdata_i,
   input  logic                      chain_mode_i,
   input  logic                      auto_init_i,
   input  logic                      xfer_i,
   output logic [BUS_W-1:0]          rdata_o,
   output logic                      tc_o,
   output logic [LOW_W+HIGH_W-1:0]   count_o
);

   localparam int unsigned CNT_W = LOW_W + HIGH_W;
   localparam int unsigned LANES = LOW_W / BUS_W;
   localparam int unsigned PTR_W = ptr_width(LANES);

   generate
      if (LOW_W % BUS_W != 0 || LANES < 1) begin : g_bad_low
         $error("LOW_W must be a nonzero multiple of BUS_W");
      end
      if (HIGH_W != BUS_W) begin : g_bad_high
         $error("HIGH_W must equal BUS_W");
      end
   endgenerate

   logic [PTR_W-1:0] ptr;
   logic [CNT_W-1:0] base, cur, nxt;
   logic             wrap, any_wr, step, tc_q;
   wr_target_e       target;

   assign any_wr = lo_wr_i | hi_wr_i;
   assign step   = xfer_i & ~any_wr & ~mclr_i;
   assign target = chain_mode_i ? WR_BASE : WR_BOTH;

   dmac_byte_ptr #(
      .LANES(LANES),
      .PTR_W(PTR_W)
   ) ptr_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr_i(mclr_i | ptr_clr_i),
      .adv_i(lo_wr_i | lo_rd_i),
      .ptr_o(ptr)
   );

   dmac_count_next #(
      .CNT_W(CNT_W)
   ) next_i (
      .cur_i      (cur),
      .base_i     (base),
      .auto_init_i(auto_init_i),
      .nxt_o      (nxt),
      .wrap_o     (wrap)
   );

   dmac_count_regs #(
      .BUS_W (BUS_W),
      .LOW_W (LOW_W),
      .HIGH_W(HIGH_W),
      .LANES (LANES),
      .PTR_W (PTR_W),
      .CNT_W (CNT_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mclr_i    (mclr_i),
      .lo_wr_i   (lo_wr_i),
      .hi_wr_i   (hi_wr_i),
      .ptr_i     (ptr),
      .wdata_i   (wdata_i),
      .target_i  (target),
      .step_i    (step),
      .step_val_i(nxt),
      .base_o    (base),
      .cur_o     (cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q <= 1'b0;
      end else begin
         tc_q <= step & wrap;
      end
   end

   logic [BUS_W-1:0] lane_w [LANES];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane_w[g] = cur[g*BUS_W +: BUS_W];
      end
   endgenerate

   logic [BUS_W-1:0] lo_sel;
   always_comb begin
      lo_sel = lane_w[0];
      for (int unsigned l = 0; l < LANES; l++) begin
         if (ptr == PTR_W'(l)) lo_sel = lane_w[l];
      end
   end

   assign rdata_o = hi_rd_i ? cur[CNT_W-1 -: BUS_W] : lo_sel;
   assign tc_o    = tc_q;
   assign count_o = cur;

endmodule

// File: rtl/dma_xfer_count_chk.sv
module dma_xfer_count_chk #(
   parameter int unsigned CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mclr_i,
   input logic             lo_wr_i,
   input logic             hi_wr_i,
   input logic             xfer_i,
   input logic             chain_mode_i,
   input logic             auto_init_i,
   input logic             tc_o,
   input logic [CNT_W-1:0] count_o
);

   // R1
   mclr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mclr_i |=> (count_o == '0) && !tc_o);

   // R5
   chain_keeps_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_mode_i && (lo_wr_i || hi_wr_i) && !mclr_i) |=> $stable(count_o));

   // R6
   dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_i && !lo_wr_i && !hi_wr_i && !mclr_i && count_o != '0)
      |=> (count_o == $past(count_o) - 1'b1) && !tc_o);

   // R7
   wrap_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_i && !lo_wr_i && !hi_wr_i && !mclr_i && count_o == '0 && !auto_init_i)
      |=> tc_o && (count_o == '1));

   // R9
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr_i || hi_wr_i) |=> !tc_o);

endmodule

bind dma_xfer_count dma_xfer_count_chk #(
   .CNT_W(LOW_W + HIGH_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .mclr_i      (mclr_i),
   .lo_wr_i     (lo_wr_i),
   .hi_wr_i     (hi_wr_i),
   .xfer_i      (xfer_i),
   .chain_mode_i(chain_mode_i),
   .auto_init_i (auto_init_i),
   .tc_o        (tc_o),
   .count_o     (count_o)
);

// File: tb/dma_xfer_count_tb.sv
`timescale 1ns/1ps
module dma_xfer_count_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mclr_i = 1'b0, ptr_clr_i = 1'b0;
   logic        lo_wr_i = 1'b0, lo_rd_i = 1'b0, hi_wr_i = 1'b0, hi_rd_i = 1'b0;
   logic [7:0]  wdata_i = '0;
   logic        chain_mode_i = 1'b0, auto_init_i = 1'b0, xfer_i = 1'b0;
   logic [7:0]  rdata_o;
   logic        tc_o;
   logic [23:0] count_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dma_xfer_count dut_i (
      .clk(clk), .rst_n(rst_n), .mclr_i(mclr_i), .ptr_clr_i(ptr_clr_i),
      .lo_wr_i(lo_wr_i), .lo_rd_i(lo_rd_i), .hi_wr_i(hi_wr_i), .hi_rd_i(hi_rd_i),
      .wdata_i(wdata_i), .chain_mode_i(chain_mode_i), .auto_init_i(auto_init_i),
      .xfer_i(xfer_i), .rdata_o(rdata_o), .tc_o(tc_o), .count_o(count_o)
   );

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse_ptr_clr();
      @(negedge clk); ptr_clr_i = 1'b1;
      @(negedge clk); ptr_clr_i = 1'b0;
   endtask

   task automatic wr_lo(input logic [7:0] d);
      @(negedge clk); lo_wr_i = 1'b1; wdata_i = d;
      @(negedge clk); lo_wr_i = 1'b0;
   endtask

   task automatic wr_hi(input logic [7:0] d);
      @(negedge clk); hi_wr_i = 1'b1; wdata_i = d;
      @(negedge clk); hi_wr_i = 1'b0;
   endtask

   task automatic load24(input logic [23:0] v);
      pulse_ptr_clr();
      wr_lo(v[7:0]);
      wr_lo(v[15:8]);
      wr_hi(v[23:16]);
   endtask

   task automatic xfer1();
      @(negedge clk); xfer_i = 1'b1;
      @(negedge clk); xfer_i = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 reset count", count_o, 24'h0);
      check("R1 reset tc", {23'h0, tc_o}, 24'h0);
   endtask

   task automatic t_load_read();
      load24(24'h561234);
      check("R2 R4 loaded count", count_o, 24'h561234);
      pulse_ptr_clr();
      @(negedge clk); lo_rd_i = 1'b1; #1;
      check("R10 read lane0", {16'h0, rdata_o}, 24'h000034);
      @(negedge clk); #1;
      check("R10 read lane1", {16'h0, rdata_o}, 24'h000012);
      lo_rd_i = 1'b0; hi_rd_i = 1'b1; #1;
      check("R10 read high", {16'h0, rdata_o}, 24'h000056);
      hi_rd_i = 1'b0;
   endtask

   task automatic t_hi_clear();
      load24(24'h561234);
      pulse_ptr_clr();
      wr_lo(8'h01);
      check("R3 low write clears high", count_o, 24'h001201);
      wr_lo(8'hAB);
      check("R2 second lane", count_o, 24'h00AB01);
      wr_lo(8'h77);
      check("R2 pointer wraps to lane0", count_o, 24'h00AB77);
   endtask

   task automatic t_dec();
      auto_init_i = 1'b0;
      load24(24'h010003);
      xfer1();
      check("R6 decrement", count_o, 24'h010002);
      check("R6 no tc", {23'h0, tc_o}, 24'h0);
      load24(24'h010000);
      xfer1();
      check("R6 borrow", count_o, 24'h00FFFF);
   endtask

   task automatic t_tc_noauto();
      auto_init_i = 1'b0;
      load24(24'h000000);
      xfer1();
      check("R7 tc strobe", {23'h0, tc_o}, 24'h1);
      check("R7 all ones", count_o, 24'hFFFFFF);
      @(negedge clk);
      check("R7 tc one cycle", {23'h0, tc_o}, 24'h0);
   endtask

   task automatic t_auto();
      auto_init_i = 1'b1;
      load24(24'h000002);
      xfer1();
      check("R8 no reload without wrap", count_o, 24'h000001);
      xfer1();
      xfer1();
      check("R8 reload on tc", count_o, 24'h000002);
      check("R8 tc on reload", {23'h0, tc_o}, 24'h1);
      auto_init_i = 1'b0;
   endtask

   task automatic t_chain();
      auto_init_i = 1'b0;
      load24(24'h000005);
      chain_mode_i = 1'b1;
      load24(24'h000009);
      check("R5 chain keeps current", count_o, 24'h000005);
      chain_mode_i = 1'b0;
      auto_init_i = 1'b1;
      for (int i = 0; i < 6; i++) xfer1();
      check("R5 R4 reload from chained base", count_o, 24'h000009);
      auto_init_i = 1'b0;
   endtask

   task automatic t_prio();
      load24(24'h000000);
      @(negedge clk); hi_wr_i = 1'b1; wdata_i = 8'h00; xfer_i = 1'b1;
      @(negedge clk); hi_wr_i = 1'b0; xfer_i = 1'b0;
      check("R9 write wins count", count_o, 24'h000000);
      check("R9 write wins tc", {23'h0, tc_o}, 24'h0);
   endtask

   task automatic t_mclr();
      load24(24'h123456);
      @(negedge clk); mclr_i = 1'b1;
      @(negedge clk); mclr_i = 1'b0;
      check("R1 mclr count", count_o, 24'h0);
      wr_lo(8'hAA);
      check("R1 mclr pointer low", count_o, 24'h0000AA);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_read();
      t_hi_clear();
      t_dec();
      t_tc_noauto();
      t_auto();
      t_chain();
      t_prio();
      t_mclr();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule